// File: doc/BRIEF.md
# Serial Debug Command Interpreter

This block sits behind a UART receiver in a target debug monitor. It reads a stream of bytes from a host and turns each one into either a command or a data byte. Data bytes are gathered into a 32-bit data register, one byte at a time. Command bytes move values between the data register, a 16-bit address register and target memory. They can also send a byte back to the host, mark the target as running, or ask for a system reset.

A byte with a value below 32 is a command. Every other byte is data. To send a data byte with a small value, the host first sends an escape command, which makes the next byte data whatever its value. Memory is reached through a request/acknowledge master port, and no new byte is taken in while a memory access is in progress. Each transmitted byte appears as a one-cycle strobe with its value.

Top module: `dbg_cmd_engine`

## Requirements
- R1: While the escape flag is clear, an accepted byte of 20h or above is data, and the data register becomes {data[23:0], byte}.
- R2: Command 00h sets the escape flag, which is status bit 0. The next accepted byte, whatever its value, is treated as data as in R1, and the flag clears.
- R3: Command 02h makes tx_valid high for exactly one cycle with tx_data equal to the old data[7:0]. It also shifts the data register right by 8 and adds 1 to the address register.
- R4: Commands 04h, 05h and 06h read 1, 2 and 4 bytes (mem_size 0, 1 and 2, mem_we 0) at the address register. The result is loaded into the data register, zero-extended.
- R5: Commands 07h, 08h and 09h write the data register to the address register with mem_we 1 and mem_size 0, 1 and 2. The memory uses the low 1, 2 or 4 bytes, least significant byte at the lowest address.
- R6: Command 0Ah loads the address register from data[15:0]. Command 0Bh reads a 2-byte word at the address register and loads it into the address register, leaving the data register unchanged.
- R7: Command 12h sets status bit 2 (run) and clears status bit 1 (trap). Status bit 7 (diagnostic) and bits 6 to 3 read 0.
- R8: Command 15h raises reset_req for one cycle when data[15:0] equals 1. With any other value it does nothing.
- R9: Any other code below 20h, such as 03h or 1Fh, leaves the data register, the address register and the status unchanged.
- R10: mem_req stays high, with mem_addr, mem_size, mem_we and mem_wdata stable, until mem_ack is seen. rx_ready is low from the accepting edge until the access completes.
- R11: After reset, the data register, the address register and the status are 0, rx_ready is 1, and tx_valid and reset_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Byte accepted when high together with rx_valid |
| tx_valid | output | 1 | One-cycle strobe of a byte to send |
| tx_data | output | 8 | Byte to send |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 2 | 0 byte, 1 word, 2 double word |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| status | output | 8 | Flags: bit 0 escape, 1 trap, 2 run, 7 diagnostic |
| data_reg | output | 32 | Data register |
| addr_reg | output | ADDR_W | Address register |
| reset_req | output | 1 | One-cycle reset request |

## Verification
Register, status, tx and reset_req results are registered on the edge that accepts the byte, so they are due one cycle after acceptance. A memory command instead finishes on the edge where mem_ack is seen, which is two cycles after the request in the bench model. The bench therefore waits at falling edges until rx_ready is high again before it reads data_reg, addr_reg and status. tx strobes and reset pulses are counted at every rising edge, so a pulse that is missing or repeated shows up in the totals.

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic [7:0]        status,
  output logic [31:0]       data_reg,
  output logic [ADDR_W-1:0] addr_reg,
  output logic              reset_req
);
  logic              busy, ind_q, esc_q, run_q;
  logic [31:0]       data_q;
  logic [ADDR_W-1:0] addr_q;

  wire accept = rx_valid && !busy;
  wire is_cmd = !esc_q && (rx_data < 8'd32);

  assign rx_ready  = !busy;
  assign mem_req   = busy;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign data_reg  = data_q;
  assign addr_reg  = addr_q;
  assign status    = {5'b0, run_q, 1'b0, esc_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; ind_q <= 1'b0; esc_q <= 1'b0; run_q <= 1'b0;
      data_q <= '0; addr_q <= '0; mem_we <= 1'b0; mem_size <= 2'd0;
      tx_valid <= 1'b0; tx_data <= 8'h00; reset_req <= 1'b0;
    end else begin
      tx_valid  <= 1'b0;
      reset_req <= 1'b0;
      if (busy) begin
        if (mem_ack) begin
          busy <= 1'b0;
          if (!mem_we) begin
            if (ind_q) addr_q <= mem_rdata[ADDR_W-1:0];
            else case (mem_size)
              2'd0:    data_q <= {24'b0, mem_rdata[7:0]};
              2'd1:    data_q <= {16'b0, mem_rdata[15:0]};
              default: data_q <= mem_rdata;
            endcase
          end
        end
      end else if (accept) begin
        if (!is_cmd) begin
          data_q <= {data_q[23:0], rx_data};
          esc_q  <= 1'b0;
        end else begin
          case (rx_data)
            8'h00: esc_q <= 1'b1;
            8'h02: begin
              tx_valid <= 1'b1;
              tx_data  <= data_q[7:0];
              data_q   <= data_q >> 8;
              addr_q   <= addr_q + 1'b1;
            end
            8'h04: begin busy <= 1'b1; mem_we <= 1'b0; mem_size <= 2'd0; ind_q <= 1'b0; end
            8'h05: begin busy <= 1'b1; mem_we <= 1'b0; mem_size <= 2'd1; ind_q <= 1'b0; end
            8'h06: begin busy <= 1'b1; mem_we <= 1'b0; mem_size <= 2'd2; ind_q <= 1'b0; end
            8'h07: begin busy <= 1'b1; mem_we <= 1'b1; mem_size <= 2'd0; ind_q <= 1'b0; end
            8'h08: begin busy <= 1'b1; mem_we <= 1'b1; mem_size <= 2'd1; ind_q <= 1'b0; end
            8'h09: begin busy <= 1'b1; mem_we <= 1'b1; mem_size <= 2'd2; ind_q <= 1'b0; end
            8'h0A: addr_q <= data_q[ADDR_W-1:0];
            8'h0B: begin busy <= 1'b1; mem_we <= 1'b0; mem_size <= 2'd1; ind_q <= 1'b1; end
            8'h12: run_q <= 1'b1;
            8'h15: if (data_q[15:0] == 16'd1) reset_req <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assert_data_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !status[0] && rx_data >= 8'd32) |=>
      data_reg == {$past(data_reg[23:0]), $past(rx_data)});

  assert_escape_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && status[0]) |=>
      !status[0] && data_reg == {$past(data_reg[23:0]), $past(rx_data)});

  assert_tx_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !status[0] && rx_data == 8'h02) |=>
      tx_valid && tx_data == $past(data_reg[7:0]));

  assert_tx_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);

  assert_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && !status[0] && (rx_data == 8'h03 || rx_data == 8'h1F)) |=>
      $stable(data_reg) && $stable(addr_reg) && $stable(status));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_size)
      && $stable(mem_we) && $stable(mem_wdata));

  assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
endmodule

// File: tb/dbg_cmd_engine_test.sv
module dbg_cmd_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic rx_ready, tx_valid, mem_req, mem_we, reset_req;
  logic [7:0] tx_data, status;
  logic [1:0] mem_size;
  logic [15:0] mem_addr, addr_reg;
  logic [31:0] mem_wdata, mem_rdata, data_reg;
  logic mem_ack;

  always #10 clk = ~clk;

  dbg_cmd_engine uut (.clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .mem_req(mem_req),
    .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .status(status), .data_reg(data_reg),
    .addr_reg(addr_reg), .reset_req(reset_req));

  logic [7:0] mem [0:255];
  logic [1:0] cnt;
  wire  [7:0] a = mem_addr[7:0];
  assign mem_rdata = {mem[a + 8'd3], mem[a + 8'd2], mem[a + 8'd1], mem[a]};

  int tx_cnt = 0, rst_cnt = 0, req_seen = 0, busy_ready = 0;
  logic [7:0] last_tx = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
      mem_ack <= 1'b0; cnt <= 2'd0;
    end else begin
      if (mem_req && !mem_ack) begin
        if (cnt == 2'd1) mem_ack <= 1'b1;
        cnt <= cnt + 2'd1;
      end else begin
        if (mem_req && mem_ack && mem_we) begin
          mem[a] <= mem_wdata[7:0];
          if (mem_size != 2'd0) mem[a + 8'd1] <= mem_wdata[15:8];
          if (mem_size == 2'd2) begin
            mem[a + 8'd2] <= mem_wdata[23:16];
            mem[a + 8'd3] <= mem_wdata[31:24];
          end
        end
        mem_ack <= 1'b0; cnt <= 2'd0;
      end
      if (tx_valid) begin tx_cnt <= tx_cnt + 1; last_tx <= tx_data; end
      if (reset_req) rst_cnt <= rst_cnt + 1;
      if (mem_req) req_seen <= req_seen + 1;
      if (mem_req && rx_ready) busy_ready <= busy_ready + 1;
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    while (!rx_ready) @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
  endtask

  // {byte, expected data, expected address, expected status}
  localparam logic [63:0] VEC [0:19] = '{
    {8'h41, 32'h00000041, 16'h0000, 8'h00},  // R1
    {8'h42, 32'h00004142, 16'h0000, 8'h00},  // R1
    {8'h43, 32'h00414243, 16'h0000, 8'h00},  // R1
    {8'h44, 32'h41424344, 16'h0000, 8'h00},  // R1
    {8'h0A, 32'h41424344, 16'h4344, 8'h00},  // R6
    {8'h09, 32'h41424344, 16'h4344, 8'h00},  // R5
    {8'h00, 32'h41424344, 16'h4344, 8'h01},  // R2
    {8'h01, 32'h42434401, 16'h4344, 8'h00},  // R2
    {8'h00, 32'h42434401, 16'h4344, 8'h01},  // R2
    {8'h00, 32'h43440100, 16'h4344, 8'h00},  // R2
    {8'h04, 32'h00000044, 16'h4344, 8'h00},  // R4
    {8'h05, 32'h00004344, 16'h4344, 8'h00},  // R4
    {8'h06, 32'h41424344, 16'h4344, 8'h00},  // R4
    {8'h03, 32'h41424344, 16'h4344, 8'h00},  // R9
    {8'h12, 32'h41424344, 16'h4344, 8'h04},  // R7
    {8'h02, 32'h00414243, 16'h4345, 8'h04},  // R3
    {8'h07, 32'h00414243, 16'h4345, 8'h04},  // R5
    {8'h05, 32'h00004243, 16'h4345, 8'h04},  // R4
    {8'h0B, 32'h00004243, 16'h4243, 8'h04},  // R6
    {8'h04, 32'h00000000, 16'h4243, 8'h04}   // R4
  };
  string TAG [0:19] = '{"R1","R1","R1","R1","R6","R5","R2","R2","R2","R2",
                        "R4","R4","R4","R9","R7","R3","R5","R4","R6","R4"};

  initial begin
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset state", {data_reg, addr_reg, status, 6'b0, rx_ready, tx_valid},
          {32'h0, 16'h0, 8'h00, 6'b0, 1'b1, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset_req idle", {63'b0, reset_req}, 64'd0);

    for (int i = 0; i < 20; i++) begin
      send(VEC[i][63:56]);
      check($sformatf("%s row %0d", TAG[i], i),
            {8'h00, data_reg, addr_reg, status}, {8'h00, VEC[i][55:0]});
      if (i == 15) check("R3 tx strobe", {32'(tx_cnt), 24'b0, last_tx}, {32'd1, 24'b0, 8'h44});
    end

    send(8'h1F);
    check("R9 code 1Fh ignored", {8'h00, data_reg, addr_reg, status}, {8'h00, 32'h0, 16'h4243, 8'h04});
    send(8'h00); send(8'h01);
    check("R2 escaped 01h", {32'h0, data_reg}, {32'h0, 32'h00000001});
    send(8'h15);
    check("R8 reset request", {32'h0, 32'(rst_cnt)}, 64'd1);
    send(8'h20);
    send(8'h15);
    check("R8 no request when low word is 0120h", {32'h0, 32'(rst_cnt)}, 64'd1);
    check("R3 no extra tx", {32'h0, 32'(tx_cnt)}, 64'd1);
    check("R10 rx_ready low while busy", {32'h0, 32'(busy_ready)}, 64'd0);
    check("R10 accesses issued", {63'b0, req_seen > 0}, 64'd1);
    check("R7 diagnostic bit clear", {63'b0, status[7]}, 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule